// File: doc/BRIEF.md
# Dual-Port Synchronous Burst RAM

This block is a true dual-port static memory of 8-bit words with two independent ports, A and B, each running on its own clock. Either port can read or write any word, and both may touch the same word in the same cycle. All inputs of a port are taken at the rising edge of that port's clock. Writes are self-timed and complete at the edge that takes the write command.

Each port holds its own address register. An edge can load it from the external address, step it up by one for burst access, clear it to zero, or leave it unchanged. A port responds only when its active-low select is low and its active-high select is high. A static mode input picks how read data comes out. In flow-through mode the word appears in the cycle right after the edge that took the read. In pipelined mode it passes through one more output register and appears one cycle later.

The data path is split into an input word, an output word and a drive-enable output per port. The drive enable marks the cycles in which the port would drive a shared bus. The address width is a parameter. The full configuration uses 15 address bits (32768 words), and the default elaborates a smaller array.

Top module: `dpram_burst`

## Requirements
- R1: A word written through either port is returned unchanged by a later read of the same address through either port.
- R2: A port acts only when x_ce_n is 0 and x_ce is 1. With any other combination a write command leaves the array unchanged and x_drive stays 0.
- R3: When x_clr_n is 0 at an edge, the address register becomes 0 and that cycle's access uses address 0. This holds whatever x_ld_n and x_cnt_n are.
- R4: When x_clr_n is 1 and x_ld_n is 0 at an edge, the address register takes x_addr, and that same edge accesses x_addr.
- R5: When x_clr_n and x_ld_n are 1 and x_cnt_n is 0, the address register steps up by one. From the top address (all ones) it steps to 0.
- R6: When x_clr_n, x_ld_n and x_cnt_n are all 1, the address register keeps its value.
- R7: With x_pipe at 0, a read taken at edge k shows its word on x_dout with x_drive at 1 between edge k and edge k+1.
- R8: With x_pipe at 1, a read taken at edge k shows its word between edge k+1 and edge k+2, and x_drive is 0 between edge k and edge k+1.
- R9: x_drive is 1 only while x_oe_n is 0 and the registered operation was a read on a selected port. x_oe_n acts at once, without waiting for a clock edge.
- R10: If one port writes an address at the same edge at which the other port reads it, the read returns the word held before the write.
- R11: After reset, both address registers are 0 and both x_drive outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released in each clock domain |
| a_clk | input | 1 | Port A clock |
| a_ce_n | input | 1 | Port A select, active low |
| a_ce | input | 1 | Port A select, active high |
| a_we_n | input | 1 | Port A operation: 0 write, 1 read |
| a_oe_n | input | 1 | Port A output enable, active low, asynchronous |
| a_pipe | input | 1 | Port A mode: 0 flow-through, 1 pipelined |
| a_ld_n | input | 1 | Port A address load strobe, active low |
| a_cnt_n | input | 1 | Port A address increment enable, active low |
| a_clr_n | input | 1 | Port A address clear, active low |
| a_addr | input | ADDR_W | Port A external address |
| a_din | input | DATA_W | Port A write data |
| a_dout | output | DATA_W | Port A read data |
| a_drive | output | 1 | Port A bus drive enable |
| b_clk | input | 1 | Port B clock |
| b_ce_n | input | 1 | Port B select, active low |
| b_ce | input | 1 | Port B select, active high |
| b_we_n | input | 1 | Port B operation: 0 write, 1 read |
| b_oe_n | input | 1 | Port B output enable, active low, asynchronous |
| b_pipe | input | 1 | Port B mode: 0 flow-through, 1 pipelined |
| b_ld_n | input | 1 | Port B address load strobe, active low |
| b_cnt_n | input | 1 | Port B address increment enable, active low |
| b_clr_n | input | 1 | Port B address clear, active low |
| b_addr | input | ADDR_W | Port B external address |
| b_din | input | DATA_W | Port B write data |
| b_dout | output | DATA_W | Port B read data |
| b_drive | output | 1 | Port B bus drive enable |

## Verification
The hardest situation to reach is a write on one port and a read on the other that land on the same address at the same edge. It needs both clocks aligned and both address registers steered to one word in the same cycle. The stimulus loads that address through the load strobe on both ports at once. It checks that the reader sees the old word, and that the next read sees the new one. The burst wrap is reached by loading the top address and then asserting only the increment enable. Clear priority is shown by pulling clear and load low together and reading a word known to sit at address 0.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

  typedef enum logic [1:0] {
    ADDR_HOLD = 2'd0,
    ADDR_INC  = 2'd1,
    ADDR_LOAD = 2'd2,
    ADDR_CLR  = 2'd3
  } addr_op_e;

endpackage

// File: rtl/dpb_rst_sync.sv
module dpb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/dpb_array.sv
module dpb_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_a,
  input  logic              wr_a,
  input  logic              rd_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] wdata_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic              clk_b,
  input  logic              wr_b,
  input  logic              rd_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] wdata_b,
  output logic [DATA_W-1:0] rdata_b
);

  localparam int DEPTH = 1 << ADDR_W;

  // Each bank is written by one port only; a word is the XOR of both banks.
  logic [DATA_W-1:0] bank_a [DEPTH];
  logic [DATA_W-1:0] bank_b [DEPTH];

  always_ff @(posedge clk_a) begin
    if (wr_a) begin
      bank_a[addr_a] <= wdata_a ^ bank_b[addr_a];
    end
    if (rd_a) begin
      rdata_a <= bank_a[addr_a] ^ bank_b[addr_a];
    end
  end

  always_ff @(posedge clk_b) begin
    if (wr_b) begin
      bank_b[addr_b] <= wdata_b ^ bank_a[addr_b];
    end
    if (rd_b) begin
      rdata_b <= bank_a[addr_b] ^ bank_b[addr_b];
    end
  end

endmodule

// File: rtl/dpb_port.sv
module dpb_port
  import dpb_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              ce,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              pipe,
  input  logic              ld_n,
  input  logic              cnt_n,
  input  logic              clr_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              arr_wr,
  output logic              arr_rd,
  output logic [DATA_W-1:0] arr_wdata,
  output logic [DATA_W-1:0] dout,
  output logic              drive
);

  addr_op_e          addr_op;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_nxt;
  logic              addr_en;
  logic              port_on;
  logic              rd_v1_q;
  logic              rd_v1_nxt;
  logic              rd_v2_q;
  logic              rd_v2_nxt;
  logic [DATA_W-1:0] pdata_q;
  logic              pdata_en;

  // Address register: clear beats load, load beats increment.
  always_comb begin
    if (!clr_n) begin
      addr_op = ADDR_CLR;
    end else if (!ld_n) begin
      addr_op = ADDR_LOAD;
    end else if (!cnt_n) begin
      addr_op = ADDR_INC;
    end else begin
      addr_op = ADDR_HOLD;
    end
  end

  always_comb begin
    unique case (addr_op)
      ADDR_CLR:  addr_nxt = '0;
      ADDR_LOAD: addr_nxt = addr_in;
      ADDR_INC:  addr_nxt = addr_q + 1'b1;
      default:   addr_nxt = addr_q;
    endcase
    addr_en = (addr_op != ADDR_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_nxt;
    end
  end

  // Access command toward the array, taken at this edge.
  always_comb begin
    port_on   = !ce_n && ce;
    arr_addr  = addr_nxt;
    arr_wr    = port_on && !we_n;
    arr_rd    = port_on && we_n;
    arr_wdata = din;
    rd_v1_nxt = arr_rd;
    rd_v2_nxt = rd_v1_q;
    pdata_en  = rd_v1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_v1_q <= 1'b0;
      rd_v2_q <= 1'b0;
    end else begin
      rd_v1_q <= rd_v1_nxt;
      rd_v2_q <= rd_v2_nxt;
    end
  end

  // Extra output stage for pipelined mode.
  always_ff @(posedge clk) begin
    if (pdata_en) begin
      pdata_q <= rd_word;
    end
  end

  always_comb begin
    if (pipe) begin
      dout  = pdata_q;
      drive = !oe_n && rd_v2_q;
    end else begin
      dout  = rd_word;
      drive = !oe_n && rd_v1_q;
    end
  end

  AST_CLR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (addr_q == '0)); // R3

  AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !ld_n) |=> (addr_q == $past(addr_in))); // R4

  AST_INC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && !cnt_n) |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1))); // R5

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && cnt_n) |=> $stable(addr_q)); // R6

  AST_DESEL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(!ce_n && ce) && !pipe) |=> (pipe || !drive)); // R2

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr && !pipe) |=> (pipe || !drive)); // R9

endmodule

// File: rtl/dpram_burst.sv
module dpram_burst #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              rst_n,
  input  logic              a_clk,
  input  logic              a_ce_n,
  input  logic              a_ce,
  input  logic              a_we_n,
  input  logic              a_oe_n,
  input  logic              a_pipe,
  input  logic              a_ld_n,
  input  logic              a_cnt_n,
  input  logic              a_clr_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_din,
  output logic [DATA_W-1:0] a_dout,
  output logic              a_drive,
  input  logic              b_clk,
  input  logic              b_ce_n,
  input  logic              b_ce,
  input  logic              b_we_n,
  input  logic              b_oe_n,
  input  logic              b_pipe,
  input  logic              b_ld_n,
  input  logic              b_cnt_n,
  input  logic              b_clr_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_din,
  output logic [DATA_W-1:0] b_dout,
  output logic              b_drive
);

  logic              a_rst_n;
  logic              b_rst_n;
  logic [ADDR_W-1:0] a_arr_addr;
  logic [ADDR_W-1:0] b_arr_addr;
  logic              a_arr_wr;
  logic              b_arr_wr;
  logic              a_arr_rd;
  logic              b_arr_rd;
  logic [DATA_W-1:0] a_arr_wdata;
  logic [DATA_W-1:0] b_arr_wdata;
  logic [DATA_W-1:0] a_rd_word;
  logic [DATA_W-1:0] b_rd_word;

  dpb_rst_sync u_rst_a (
    .clk        (a_clk),
    .rst_n      (rst_n),
    .rst_sync_n (a_rst_n)
  );

  dpb_rst_sync u_rst_b (
    .clk        (b_clk),
    .rst_n      (rst_n),
    .rst_sync_n (b_rst_n)
  );

  dpb_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_a (
    .clk       (a_clk),
    .rst_n     (a_rst_n),
    .ce_n      (a_ce_n),
    .ce        (a_ce),
    .we_n      (a_we_n),
    .oe_n      (a_oe_n),
    .pipe      (a_pipe),
    .ld_n      (a_ld_n),
    .cnt_n     (a_cnt_n),
    .clr_n     (a_clr_n),
    .addr_in   (a_addr),
    .din       (a_din),
    .rd_word   (a_rd_word),
    .arr_addr  (a_arr_addr),
    .arr_wr    (a_arr_wr),
    .arr_rd    (a_arr_rd),
    .arr_wdata (a_arr_wdata),
    .dout      (a_dout),
    .drive     (a_drive)
  );

  dpb_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_b (
    .clk       (b_clk),
    .rst_n     (b_rst_n),
    .ce_n      (b_ce_n),
    .ce        (b_ce),
    .we_n      (b_we_n),
    .oe_n      (b_oe_n),
    .pipe      (b_pipe),
    .ld_n      (b_ld_n),
    .cnt_n     (b_cnt_n),
    .clr_n     (b_clr_n),
    .addr_in   (b_addr),
    .din       (b_din),
    .rd_word   (b_rd_word),
    .arr_addr  (b_arr_addr),
    .arr_wr    (b_arr_wr),
    .arr_rd    (b_arr_rd),
    .arr_wdata (b_arr_wdata),
    .dout      (b_dout),
    .drive     (b_drive)
  );

  dpb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_a   (a_clk),
    .wr_a    (a_arr_wr),
    .rd_a    (a_arr_rd),
    .addr_a  (a_arr_addr),
    .wdata_a (a_arr_wdata),
    .rdata_a (a_rd_word),
    .clk_b   (b_clk),
    .wr_b    (b_arr_wr),
    .rd_b    (b_arr_rd),
    .addr_b  (b_arr_addr),
    .wdata_b (b_arr_wdata),
    .rdata_b (b_rd_word)
  );

endmodule

// File: tb/dpram_burst_bench.sv
module dpram_burst_bench;

  localparam int PERIOD = 10;
  localparam int AW     = 11;
  localparam int DW     = 8;
  localparam int NROWS  = 11;

  typedef struct packed {
    logic          we_n;
    logic          ld_n;
    logic          cnt_n;
    logic          clr_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic          chk;
    logic [DW-1:0] exp;
  } row_t;

  // One row per port-A cycle, flow-through, selected, output enabled.
  localparam row_t TBL [NROWS] = '{
    '{1'b0, 1'b0, 1'b1, 1'b1, 11'h000, 8'h5A, 1'b0, 8'h00}, // write 0
    '{1'b0, 1'b0, 1'b1, 1'b1, 11'h010, 8'h11, 1'b0, 8'h00}, // R4 load
    '{1'b0, 1'b1, 1'b0, 1'b1, 11'h000, 8'h22, 1'b0, 8'h00}, // R5 burst 0x011
    '{1'b0, 1'b1, 1'b0, 1'b1, 11'h000, 8'h33, 1'b0, 8'h00}, // R5 burst 0x012
    '{1'b1, 1'b0, 1'b1, 1'b1, 11'h010, 8'h00, 1'b1, 8'h11}, // R4 R7
    '{1'b1, 1'b1, 1'b0, 1'b1, 11'h000, 8'h00, 1'b1, 8'h22}, // R5
    '{1'b1, 1'b1, 1'b1, 1'b1, 11'h3FF, 8'h00, 1'b1, 8'h22}, // R6 hold
    '{1'b1, 1'b1, 1'b0, 1'b1, 11'h000, 8'h00, 1'b1, 8'h33}, // R5
    '{1'b1, 1'b0, 1'b0, 1'b0, 11'h012, 8'h00, 1'b1, 8'h5A}, // R3 clear wins
    '{1'b0, 1'b0, 1'b1, 1'b1, 11'h7FF, 8'hC3, 1'b0, 8'h00}, // top address
    '{1'b1, 1'b1, 1'b0, 1'b1, 11'h000, 8'h00, 1'b1, 8'h5A}  // R5 wrap to 0
  };

  logic          rst_n;
  logic          a_clk, b_clk;
  logic          a_ce_n, a_ce, a_we_n, a_oe_n, a_pipe, a_ld_n, a_cnt_n, a_clr_n;
  logic          b_ce_n, b_ce, b_we_n, b_oe_n, b_pipe, b_ld_n, b_cnt_n, b_clr_n;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_din, b_din;
  logic [DW-1:0] a_dout, b_dout;
  logic          a_drive, b_drive;

  int checks;
  int errors;
  bit done;

  dpram_burst #(.ADDR_W(AW), .DATA_W(DW)) u_dpram_burst (
    .rst_n   (rst_n),
    .a_clk   (a_clk),   .a_ce_n (a_ce_n), .a_ce   (a_ce),   .a_we_n (a_we_n),
    .a_oe_n  (a_oe_n),  .a_pipe (a_pipe), .a_ld_n (a_ld_n), .a_cnt_n(a_cnt_n),
    .a_clr_n (a_clr_n), .a_addr (a_addr), .a_din  (a_din),  .a_dout (a_dout),
    .a_drive (a_drive),
    .b_clk   (b_clk),   .b_ce_n (b_ce_n), .b_ce   (b_ce),   .b_we_n (b_we_n),
    .b_oe_n  (b_oe_n),  .b_pipe (b_pipe), .b_ld_n (b_ld_n), .b_cnt_n(b_cnt_n),
    .b_clr_n (b_clr_n), .b_addr (b_addr), .b_din  (b_din),  .b_dout (b_dout),
    .b_drive (b_drive)
  );

  initial a_clk = 1'b0;
  initial b_clk = 1'b0;
  always #(PERIOD/2) a_clk = ~a_clk;
  always #(PERIOD/2) b_clk = ~b_clk;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge a_clk);
    @(negedge a_clk);
  endtask

  task automatic a_idle;
    a_ce_n = 1'b1; a_ce = 1'b0; a_we_n = 1'b1;
    a_ld_n = 1'b1; a_cnt_n = 1'b1; a_clr_n = 1'b1;
  endtask

  task automatic b_idle;
    b_ce_n = 1'b1; b_ce = 1'b0; b_we_n = 1'b1;
    b_ld_n = 1'b1; b_cnt_n = 1'b1; b_clr_n = 1'b1;
  endtask

  task automatic a_op(input logic we_n, input logic ld_n, input logic cnt_n,
                      input logic clr_n, input logic [AW-1:0] addr, input logic [DW-1:0] din);
    a_ce_n = 1'b0; a_ce = 1'b1; a_we_n = we_n;
    a_ld_n = ld_n; a_cnt_n = cnt_n; a_clr_n = clr_n;
    a_addr = addr; a_din = din;
  endtask

  task automatic b_op(input logic we_n, input logic [AW-1:0] addr, input logic [DW-1:0] din);
    b_ce_n = 1'b0; b_ce = 1'b1; b_we_n = we_n;
    b_ld_n = 1'b0; b_cnt_n = 1'b1; b_clr_n = 1'b1;
    b_addr = addr; b_din = din;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0;
    a_idle(); b_idle();
    a_oe_n = 1'b0; b_oe_n = 1'b0; a_pipe = 1'b0; b_pipe = 1'b0;
    a_addr = '0; b_addr = '0; a_din = '0; b_din = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R11: no drive after reset
    check("R11 a_drive after reset", {7'd0, a_drive}, 8'h01 & 8'h00);
    check("R11 b_drive after reset", {7'd0, b_drive}, 8'h00);

    // R11: address register is 0 after reset -> hold-write lands at 0
    a_op(1'b0, 1'b1, 1'b1, 1'b1, 11'h555, 8'h77);
    tick();
    a_idle();
    b_op(1'b1, 11'h000, 8'h00);
    tick();
    check("R11 reset address zero, read via B (R1)", b_dout, 8'h77);
    b_idle();

    // Table walk: R3 R4 R5 R6 R7
    for (int i = 0; i < NROWS; i++) begin
      a_op(TBL[i].we_n, TBL[i].ld_n, TBL[i].cnt_n, TBL[i].clr_n, TBL[i].addr, TBL[i].din);
      tick();
      if (TBL[i].chk) begin
        check($sformatf("table row %0d (R3/R4/R5/R6/R7) data", i), a_dout, TBL[i].exp);
        check($sformatf("table row %0d (R7) drive", i), {7'd0, a_drive}, 8'h01);
      end
    end
    a_idle();
    tick();

    // R2: deselected write is ignored, deselected read gives no drive
    a_op(1'b0, 1'b0, 1'b1, 1'b1, 11'h010, 8'hEE);
    a_ce_n = 1'b0; a_ce = 1'b0;
    tick();
    check("R2 no drive, ce low", {7'd0, a_drive}, 8'h00);
    a_op(1'b1, 1'b0, 1'b1, 1'b1, 11'h010, 8'h00);
    a_ce_n = 1'b1; a_ce = 1'b1;
    tick();
    check("R2 no drive, ce_n high", {7'd0, a_drive}, 8'h00);
    a_op(1'b1, 1'b0, 1'b1, 1'b1, 11'h010, 8'h00);
    tick();
    check("R2 deselected write ignored", a_dout, 8'h11);

    // R9: output enable gates drive without a clock edge
    a_oe_n = 1'b1;
    a_op(1'b1, 1'b0, 1'b1, 1'b1, 11'h011, 8'h00);
    tick();
    check("R9 oe_n high blocks drive", {7'd0, a_drive}, 8'h00);
    #1 a_oe_n = 1'b0;
    #1;
    check("R9 oe_n low drives at once", {7'd0, a_drive}, 8'h01);
    check("R9 data while driven", a_dout, 8'h22);
    a_idle();
    tick();
    check("R9 no drive after write-free idle", {7'd0, a_drive}, 8'h00);

    // R8: pipelined read on port B
    b_pipe = 1'b1;
    b_op(1'b1, 11'h012, 8'h00);
    tick();
    check("R8 no drive in first cycle", {7'd0, b_drive}, 8'h00);
    b_idle();
    tick();
    check("R8 drive in second cycle", {7'd0, b_drive}, 8'h01);
    check("R8 data in second cycle", b_dout, 8'h33);
    tick();
    check("R8 drive released", {7'd0, b_drive}, 8'h00);
    b_pipe = 1'b0;

    // R10: same-address write on A and read on B at one edge
    a_op(1'b0, 1'b0, 1'b1, 1'b1, 11'h012, 8'h99);
    b_op(1'b1, 11'h012, 8'h00);
    tick();
    check("R10 read returns old word", b_dout, 8'h33);
    a_idle();
    b_op(1'b1, 11'h012, 8'h00);
    tick();
    check("R10 next read returns new word", b_dout, 8'h99);
    b_idle();

    // R1: B writes, A reads
    b_op(1'b0, 11'h100, 8'hA5);
    tick();
    b_idle();
    a_op(1'b1, 1'b0, 1'b1, 1'b1, 11'h100, 8'h00);
    tick();
    check("R1 A reads word written by B", a_dout, 8'hA5);
    a_idle();
    tick();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule